// File: doc/BRIEF.md
# Sleep-Strobe Power Mode Controller

This block picks the low-power mode a processor core enters when it executes its sleep instruction. At the cycle the one-cycle sleep strobe is seen, the block samples an idle-enable bit, a deep-sleep-enable bit and a two-bit clock select. From these it drives a CPU clock gate enable, a peripheral clock gate enable and a request to switch the voltage regulator fully off. It also reports the current mode and clock source. Between strobes the control bits have no effect on the low-power state. A later strobe samples them again, so any new bit values take effect then.

A wake event returns the block from idle or sleep to a run mode chosen by the clock select bits at wake time. Deep sleep ignores wake and is left only through reset. After reset the block runs from the primary source. When the two-speed start-up input is high during reset, it instead runs from the internal source until the primary source reports ready. Wake-source decoding, the regulator and the actual clock multiplexing are handled outside this block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A cycle with `rst` high and `two_speed_en` low leaves `mode`=0 (run), `cpu_clk_en`=1, `per_clk_en`=1, `reg_off_req`=0 and `clk_src`=00 (primary).
- R2: A cycle with `rst` and `two_speed_en` both high leaves run mode with `clk_src`=11 (internal). `clk_src` stays 11 until `pri_ready` is sampled high, and reads 00 from the following cycle.
- R3: In run mode (`mode`=0), both clock enables are 1 and `reg_off_req` is 0. Outside start-up, `clk_src` follows `clk_sel` one cycle later, with 00 giving primary, 01 secondary, 11 internal, and the unused code 10 read as primary (00).
- R4: A strobe with `deep_en`=1, whatever the value of `idle_en`, gives `mode`=3, both clock enables 0 and `reg_off_req`=1 on the next cycle. `clk_src` holds the decoded select sampled with the strobe.
- R5: A strobe with `deep_en`=0 and `idle_en`=0 gives `mode`=2, both clock enables 0 and `reg_off_req`=0 on the next cycle. `clk_src` holds the decoded select sampled with the strobe.
- R6: A strobe with `idle_en`=1 and `deep_en`=0 gives `mode`=1, `cpu_clk_en`=0, `per_clk_en`=1 and `reg_off_req`=0. `clk_src` shows the idle variant picked by `clk_sel` at the strobe (00, 01 or 11).
- R7: The control bits are taken only in the strobe cycle. Changes to them while in a low-power mode leave every output unchanged. A later strobe from run mode uses the new values.
- R8: A strobe that arrives while `mode` is not 0 is ignored.
- R9: `wake` in idle or sleep gives `mode`=0 and `cpu_clk_en`=1 on the next cycle, with `clk_src` from `clk_sel` at wake. `wake` in run mode has no effect.
- R10: In deep sleep, `wake` is ignored and only `rst` brings the block back to its reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| two_speed_en | input | 1 | Start from the internal source after reset |
| pri_ready | input | 1 | Primary source is stable |
| sleep_stb | input | 1 | One-cycle pulse: sleep instruction executed |
| idle_en | input | 1 | Idle-enable control bit |
| deep_en | input | 1 | Deep-sleep-enable control bit |
| clk_sel | input | 2 | Clock select bits |
| wake | input | 1 | Wake event |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| reg_off_req | output | 1 | Request to switch the regulator off |
| mode | output | 2 | 0 run, 1 idle, 2 sleep, 3 deep sleep |
| clk_src | output | 2 | Current source: 00 primary, 01 secondary, 11 internal |

## Verification
The strobe is applied with every combination of the two enable bits that matters. Deep sleep is entered with idle enable also set, which shows that deep sleep takes priority. Idle is entered with each of the three select codes, which separates the idle variants from one another. The control bits are changed while the block is idle, both with and without a fresh strobe, which separates sampling at the strobe from continuous tracking. Wake is applied in run, idle, sleep and deep sleep, and the two reset flavours are compared to show how the start-up source differs.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_DEEP  = 2'd3
  } pm_mode_e;

  localparam logic [SEL_W-1:0] SRC_PRI = 2'b00;
  localparam logic [SEL_W-1:0] SRC_SEC = 2'b01;
  localparam logic [SEL_W-1:0] SRC_INT = 2'b11;

  function automatic logic [SEL_W-1:0] map_src(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b01:   map_src = SRC_SEC;
      2'b11:   map_src = SRC_INT;
      default: map_src = SRC_PRI;
    endcase
  endfunction
endpackage

// File: rtl/pmc_target_decode.sv
module pmc_target_decode
  import pmc_pkg::*;
(
  input  logic             idle_en,
  input  logic             deep_en,
  input  logic [SEL_W-1:0] clk_sel,
  output pm_mode_e         tgt_mode,
  output logic [SEL_W-1:0] tgt_src
);
  always_comb begin
    if (deep_en)      tgt_mode = PM_DEEP;
    else if (idle_en) tgt_mode = PM_IDLE;
    else              tgt_mode = PM_SLEEP;
    tgt_src = map_src(clk_sel);
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             two_speed_en,
  input  logic             pri_ready,
  input  logic             sleep_stb,
  input  logic             wake,
  input  pm_mode_e         tgt_mode,
  input  logic [SEL_W-1:0] tgt_src,
  output pm_mode_e         mode_d,
  output logic [SEL_W-1:0] src_d
);
  pm_mode_e         mode_q;
  logic [SEL_W-1:0] src_q;
  logic             start_q, start_d;

  always_comb begin
    mode_d  = mode_q;
    src_d   = src_q;
    start_d = start_q;
    case (mode_q)
      PM_RUN: begin
        if (sleep_stb) begin
          mode_d  = tgt_mode;
          src_d   = tgt_src;
          start_d = 1'b0;
        end else if (start_q) begin
          if (pri_ready) begin
            start_d = 1'b0;
            src_d   = SRC_PRI;
          end else begin
            src_d   = SRC_INT;
          end
        end else begin
          src_d = tgt_src;
        end
      end
      PM_IDLE, PM_SLEEP: begin
        if (wake) begin
          mode_d = PM_RUN;
          src_d  = tgt_src;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PM_RUN;
      start_q <= two_speed_en;
      src_q   <= two_speed_en ? SRC_INT : SRC_PRI;
    end else begin
      mode_q  <= mode_d;
      start_q <= start_d;
      src_q   <= src_d;
    end
  end

  AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_DEEP) |=> (mode_q == PM_DEEP)); // R10

  AST_STB_LOWPWR: assert property (@(posedge clk) disable iff (rst)
    (mode_q != PM_RUN && !wake) |=> $stable(mode_q) && $stable(src_q)); // R8

  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == PM_IDLE || mode_q == PM_SLEEP) && wake) |=> (mode_q == PM_RUN)); // R9
endmodule

// File: rtl/pmc_gate_regs.sv
module pmc_gate_regs
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             two_speed_en,
  input  pm_mode_e         mode_d,
  input  logic [SEL_W-1:0] src_d,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             reg_off_req,
  output logic [1:0]       mode_o,
  output logic [SEL_W-1:0] src_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en  <= 1'b1;
      per_clk_en  <= 1'b1;
      reg_off_req <= 1'b0;
      mode_o      <= PM_RUN;
      src_o       <= two_speed_en ? SRC_INT : SRC_PRI;
    end else begin
      cpu_clk_en  <= (mode_d == PM_RUN);
      per_clk_en  <= (mode_d == PM_RUN) || (mode_d == PM_IDLE);
      reg_off_req <= (mode_d == PM_DEEP);
      mode_o      <= mode_d;
      src_o       <= src_d;
    end
  end

  AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    (mode_o == PM_RUN) |-> (cpu_clk_en && per_clk_en && !reg_off_req)); // R3

  AST_IDLE_GATE: assert property (@(posedge clk) disable iff (rst)
    (mode_o == PM_IDLE) |-> (!cpu_clk_en && per_clk_en && !reg_off_req)); // R6

  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
    (mode_o == PM_SLEEP) |-> (!cpu_clk_en && !per_clk_en && !reg_off_req)); // R5

  AST_DEEP_REG: assert property (@(posedge clk) disable iff (rst)
    reg_off_req |-> (mode_o == PM_DEEP && !cpu_clk_en && !per_clk_en)); // R4
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       two_speed_en,
  input  logic       pri_ready,
  input  logic       sleep_stb,
  input  logic       idle_en,
  input  logic       deep_en,
  input  logic [1:0] clk_sel,
  input  logic       wake,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       reg_off_req,
  output logic [1:0] mode,
  output logic [1:0] clk_src
);
  pm_mode_e         tgt_mode, mode_d;
  logic [SEL_W-1:0] tgt_src, src_d;

  pmc_target_decode u_decode (
    .idle_en  (idle_en),
    .deep_en  (deep_en),
    .clk_sel  (clk_sel),
    .tgt_mode (tgt_mode),
    .tgt_src  (tgt_src)
  );

  pmc_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .two_speed_en (two_speed_en),
    .pri_ready    (pri_ready),
    .sleep_stb    (sleep_stb),
    .wake         (wake),
    .tgt_mode     (tgt_mode),
    .tgt_src      (tgt_src),
    .mode_d       (mode_d),
    .src_d        (src_d)
  );

  pmc_gate_regs u_gates (
    .clk          (clk),
    .rst          (rst),
    .two_speed_en (two_speed_en),
    .mode_d       (mode_d),
    .src_d        (src_d),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .reg_off_req  (reg_off_req),
    .mode_o       (mode),
    .src_o        (clk_src)
  );

  AST_WAKE_CPU: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd1 || mode == 2'd2) && wake) |=> cpu_clk_en); // R9
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       two_speed_en = 1'b0;
  logic       pri_ready = 1'b0;
  logic       sleep_stb = 1'b0;
  logic       idle_en = 1'b0;
  logic       deep_en = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic       wake = 1'b0;
  logic       cpu_clk_en, per_clk_en, reg_off_req;
  logic [1:0] mode, clk_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .two_speed_en(two_speed_en), .pri_ready(pri_ready),
    .sleep_stb(sleep_stb), .idle_en(idle_en), .deep_en(deep_en),
    .clk_sel(clk_sel), .wake(wake), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .reg_off_req(reg_off_req), .mode(mode),
    .clk_src(clk_src)
  );

  function automatic logic [6:0] ex(input logic [1:0] m, input logic c,
                                    input logic p, input logic r,
                                    input logic [1:0] s);
    return {m, c, p, r, s};
  endfunction

  task automatic step(input logic r, input logic ts, input logic pr,
                      input logic stb, input logic ie, input logic de,
                      input logic [1:0] sel, input logic wk,
                      input logic [6:0] e, input string tag);
    @(negedge clk);
    rst = r; two_speed_en = ts; pri_ready = pr; sleep_stb = stb;
    idle_en = ie; deep_en = de; clk_sel = sel; wake = wk;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [6:0] e;
        logic [6:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {mode, cpu_clk_en, per_clk_en, reg_off_req, clk_src};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual mode=%0d cpu=%b per=%b roff=%b src=%b expected mode=%0d cpu=%b per=%b roff=%b src=%b",
                   t, a[6:5], a[4], a[3], a[2], a[1:0], e[6:5], e[4], e[3], e[2], e[1:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    // R1 reset state
    step(1, 0, 0, 0, 0, 0, 2'b00, 0, ex(0, 1, 1, 0, 2'b00), "R1 reset");
    step(0, 0, 0, 0, 0, 0, 2'b00, 0, ex(0, 1, 1, 0, 2'b00), "R3 run primary");
    // R6 idle secondary variant
    step(0, 0, 0, 1, 1, 0, 2'b01, 0, ex(1, 0, 1, 0, 2'b01), "R6 idle sec");
    // R7 bits change without strobe
    step(0, 0, 0, 0, 0, 1, 2'b11, 0, ex(1, 0, 1, 0, 2'b01), "R7 no resample");
    // R8 strobe while idle ignored
    step(0, 0, 0, 1, 0, 1, 2'b11, 0, ex(1, 0, 1, 0, 2'b01), "R8 stb ignored");
    // R9 wake from idle
    step(0, 0, 0, 0, 0, 0, 2'b11, 1, ex(0, 1, 1, 0, 2'b11), "R9 wake idle");
    // R5 sleep
    step(0, 0, 0, 1, 0, 0, 2'b11, 0, ex(2, 0, 0, 0, 2'b11), "R5 sleep");
    step(0, 0, 0, 0, 1, 0, 2'b00, 0, ex(2, 0, 0, 0, 2'b11), "R7 sleep hold");
    step(0, 0, 0, 0, 0, 0, 2'b00, 1, ex(0, 1, 1, 0, 2'b00), "R9 wake sleep");
    // R7 new strobe uses new bits, R6 internal variant
    step(0, 0, 0, 1, 1, 0, 2'b11, 0, ex(1, 0, 1, 0, 2'b11), "R6 idle int");
    step(0, 0, 0, 0, 1, 0, 2'b00, 1, ex(0, 1, 1, 0, 2'b00), "R9 wake idle2");
    step(0, 0, 0, 1, 1, 0, 2'b00, 0, ex(1, 0, 1, 0, 2'b00), "R6 idle pri");
    step(0, 0, 0, 0, 0, 0, 2'b00, 1, ex(0, 1, 1, 0, 2'b00), "R9 wake idle3");
    // R9 wake in run ignored, R3 run follows select
    step(0, 0, 0, 0, 0, 0, 2'b01, 1, ex(0, 1, 1, 0, 2'b01), "R9 wake in run");
    step(0, 0, 0, 0, 0, 0, 2'b10, 0, ex(0, 1, 1, 0, 2'b00), "R3 sel 10 primary");
    // R4 deep takes priority over idle
    step(0, 0, 0, 1, 1, 1, 2'b01, 0, ex(3, 0, 0, 1, 2'b01), "R4 deep");
    step(0, 0, 0, 0, 0, 0, 2'b00, 1, ex(3, 0, 0, 1, 2'b01), "R10 wake ignored");
    step(0, 0, 0, 1, 0, 0, 2'b00, 0, ex(3, 0, 0, 1, 2'b01), "R10 deep hold");
    // R2 two-speed start-up
    step(1, 1, 0, 0, 0, 0, 2'b00, 0, ex(0, 1, 1, 0, 2'b11), "R2 reset internal");
    step(0, 1, 0, 0, 0, 0, 2'b00, 0, ex(0, 1, 1, 0, 2'b11), "R2 wait ready");
    step(0, 1, 0, 0, 0, 0, 2'b01, 0, ex(0, 1, 1, 0, 2'b11), "R2 wait ready2");
    step(0, 1, 1, 0, 0, 0, 2'b00, 0, ex(0, 1, 1, 0, 2'b00), "R2 primary ready");
    step(0, 0, 0, 0, 0, 0, 2'b01, 0, ex(0, 1, 1, 0, 2'b01), "R3 after startup");
    // R1 reset from deep sleep path
    step(0, 0, 0, 1, 0, 1, 2'b00, 0, ex(3, 0, 0, 1, 2'b00), "R4 deep again");
    step(1, 0, 0, 0, 0, 0, 2'b11, 0, ex(0, 1, 1, 0, 2'b00), "R10 reset exit");
    step(0, 0, 0, 0, 0, 0, 2'b00, 0, ex(0, 1, 1, 0, 2'b00), "R1 run after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule